// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real frame address by walking page tables held in memory. Depending on a two-bit type field in the root descriptor, the walk starts at one of four table levels: three region levels or the segment level. It always ends at a page table. The block takes the root descriptor from one of three control-register inputs, chosen by the address-space mode of the request. It fetches one 64-bit entry at a time over a simple request/acknowledge memory port and checks every entry it reads.

When the walk ends, the block reports either a real address with read, write and execute permissions, or a fault. A fault carries a program exception code and a tagged fault address. Translation can be switched off entirely, and 31-bit addressing masks the virtual address before any other step. There is no TLB: each request costs one full walk. The block accepts a new request only while it is idle.

Top module: `xlate_walker`

## Requirements
- R1: With `xlate_en` low the result is never a fault, `real_addr` equals the virtual address with its low 12 bits cleared, all three permissions are 1, and no memory read is issued.
- R2: With `wide_addr` low the virtual address is ANDed with 0x7fffffff before any other step, including bypass, reach checks and table indexing.
- R3: `req_mode` 1 selects `root_pri`, 2 selects `root_sec` and 3 selects `root_home`; the effective mode bits used in fault addresses are the same codes.
- R4: Root and entry type field is bits [3:2] (3 region-first, 2 region-second, 1 region-third, 0 segment). The walk reads the table for the root's type, then each lower table, then the page table. Entry address = origin + offset. The offset is (va>>50)&0x3ff8, (va>>39)&0x3ff8, (va>>28)&0x3ff8, (va>>17)&0x3ff8 or (va>>9)&0x7f8 for the region-first, region-second, region-third, segment and page table respectively. The origin is the descriptor with bits [11:0] cleared, except that the page-table origin from a segment entry clears only bits [10:0].
- R5: A virtual address with any bit set in 0xffe0000000000000 (region-second root), 0xfffffc0000000000 (region-third root) or 0xffffffff80000000 (segment root) faults with code 0x12 and no memory read.
- R6: Root bit 5 or a region/segment entry bit 5 set faults with code 0x10. Page entry bit 10 set faults with code 0x11.
- R7: A region or segment entry read from a table whose expected next type differs from its bits [3:2] faults with code 0x12. The expected type is one below the table it came from, and 0 for entries read from the segment table.
- R8: A root with bit 4 set (and bit 5 clear) maps directly: `real_addr` = page-aligned virtual address, no memory read.
- R9: A successful walk returns the page entry with bits [11:0] cleared. Page entry bit 9 clears write permission, and a write (`req_kind` 1) to a non-writable page faults with code 0x04.
- R10: `fault_addr` is the page-aligned virtual address ORed with the effective mode bits (1, 2 or 3), and additionally with 4 for a protection fault.
- R11: In secondary mode an instruction fetch (`req_kind` 2) walks through `root_pri` with effective mode 1 and returns read=write=0. Other accesses walk through `root_sec` and return execute=0.
- R12: A request is accepted only when `busy` is low; a request offered while busy is ignored. At most one memory read is outstanding, and `mem_req` holds with a stable `mem_addr` until `mem_ack`. `done` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_mode | input | 2 | Address-space mode: 1 primary, 2 secondary, 3 home |
| xlate_en | input | 1 | Translation enable |
| wide_addr | input | 1 | 1 = 64-bit addressing, 0 = 31-bit |
| root_pri | input | 64 | Primary root descriptor |
| root_sec | input | 64 | Secondary root descriptor |
| root_home | input | 64 | Home root descriptor |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read address |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 64 | Read data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Result is a fault |
| fault_code | output | 8 | Program exception code |
| fault_addr | output | 64 | Tagged fault address |
| real_addr | output | 64 | Translated frame address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
A corrupted level counter or origin register makes the walker read the wrong address. This shows at the ports within the same request, as a wrong frame, a spurious fault code or a number of memory reads that differs from the table depth, and all of it is compared when `done` pulses. A stuck mode or permission register shows as a wrong tag in `fault_addr` or a wrong permission bit on the very next result. A handshake fault shows as an extra or missing `done` pulse as soon as a request is offered while busy.

// File: rtl/xlate_walker.sv
module xlate_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_va,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_mode,
  input  logic        xlate_en,
  input  logic        wide_addr,
  input  logic [63:0] root_pri,
  input  logic [63:0] root_sec,
  input  logic [63:0] root_home,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_data,
  output logic        done,
  output logic        fault,
  output logic [7:0]  fault_code,
  output logic [63:0] fault_addr,
  output logic [63:0] real_addr,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x
);
  typedef enum logic [1:0] {S_IDLE, S_ROOT, S_READ, S_RESP} st_t;

  st_t         state;
  logic [63:0] va_q, root_q;
  logic [1:0]  asc_q, kind_q;
  logic [2:0]  lvl_q;
  logic        sec_fetch_q;

  function automatic logic [63:0] tbl_off(input logic [2:0] l, input logic [63:0] v);
    case (l)
      3'd4:    tbl_off = (v >> 50) & 64'h3ff8;
      3'd3:    tbl_off = (v >> 39) & 64'h3ff8;
      3'd2:    tbl_off = (v >> 28) & 64'h3ff8;
      3'd1:    tbl_off = (v >> 17) & 64'h3ff8;
      default: tbl_off = (v >> 9)  & 64'h07f8;
    endcase
  endfunction

  wire [63:0] va_m   = wide_addr ? req_va : (req_va & 64'h7fff_ffff);
  wire [63:0] va_pg  = va_m & ~64'hfff;
  wire        sfetch = (req_mode == 2'd2) && (req_kind == 2'd2);
  wire [1:0]  asc_in = (sfetch || req_mode == 2'd0) ? 2'd1 : req_mode;
  wire [63:0] root_in = (asc_in == 2'd1) ? root_pri : (asc_in == 2'd2) ? root_sec : root_home;
  wire        sdata  = (req_mode == 2'd2) && !sfetch;

  assign busy = (state != S_IDLE);
  assign done = (state == S_RESP);

  logic        reach_bad;
  always_comb
    case (root_q[3:2])
      2'd2:    reach_bad = |(va_q & 64'hffe0_0000_0000_0000);
      2'd1:    reach_bad = |(va_q & 64'hffff_fc00_0000_0000);
      2'd0:    reach_bad = |(va_q & 64'hffff_ffff_8000_0000);
      default: reach_bad = 1'b0;
    endcase

  logic        f_en, f_prot, ok_en, issue, ro;
  logic [7:0]  f_code;
  logic [63:0] ok_addr, nx_addr;
  logic [2:0]  nx_lvl;

  always_comb begin
    f_en = 1'b0; f_prot = 1'b0; f_code = 8'h00;
    ok_en = 1'b0; ok_addr = va_q; issue = 1'b0;
    nx_addr = 64'h0; nx_lvl = lvl_q; ro = 1'b0;
    case (state)
      S_ROOT: begin
        nx_lvl = {1'b0, root_q[3:2]} + 3'd1;
        if (reach_bad) begin f_en = 1'b1; f_code = 8'h12; end
        else if (root_q[5]) begin f_en = 1'b1; f_code = 8'h10; end
        else if (root_q[4]) ok_en = 1'b1;
        else begin
          issue = 1'b1;
          nx_addr = (root_q & ~64'hfff) + tbl_off(nx_lvl, va_q);
        end
      end
      S_READ: if (mem_ack) begin
        if (lvl_q != 3'd0) begin
          nx_lvl = lvl_q - 3'd1;
          if (mem_data[5]) begin f_en = 1'b1; f_code = 8'h10; end
          else if ({1'b0, mem_data[3:2]} != nx_lvl) begin f_en = 1'b1; f_code = 8'h12; end
          else begin
            issue = 1'b1;
            nx_addr = (mem_data & ((lvl_q == 3'd1) ? ~64'h7ff : ~64'hfff)) + tbl_off(nx_lvl, va_q);
          end
        end else begin
          ro = mem_data[9];
          if (mem_data[10]) begin f_en = 1'b1; f_code = 8'h11; end
          else if (kind_q == 2'd1 && (!perm_w || ro)) begin
            f_en = 1'b1; f_prot = 1'b1; f_code = 8'h04;
          end else begin
            ok_en = 1'b1; ok_addr = mem_data & ~64'hfff;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; mem_req <= 1'b0; mem_addr <= 64'h0;
      va_q <= 64'h0; root_q <= 64'h0; asc_q <= 2'd1; kind_q <= 2'd0;
      lvl_q <= 3'd0; sec_fetch_q <= 1'b0;
      fault <= 1'b0; fault_code <= 8'h00; fault_addr <= 64'h0; real_addr <= 64'h0;
      perm_r <= 1'b0; perm_w <= 1'b0; perm_x <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q <= va_pg; root_q <= root_in; asc_q <= asc_in; kind_q <= req_kind;
          sec_fetch_q <= xlate_en && sfetch;
          fault <= 1'b0;
          if (!xlate_en) begin
            real_addr <= va_pg;
            perm_r <= 1'b1; perm_w <= 1'b1; perm_x <= 1'b1;
            state <= S_RESP;
          end else begin
            perm_r <= !sfetch; perm_w <= !sfetch; perm_x <= !sdata;
            state <= S_ROOT;
          end
        end
        S_RESP: state <= S_IDLE;
        default: begin
          if (f_en) begin
            fault <= 1'b1; fault_code <= f_code;
            fault_addr <= va_q | {61'h0, f_prot, asc_q};
            mem_req <= 1'b0; state <= S_RESP;
          end else if (ok_en) begin
            real_addr <= ok_addr;
            if (ro) perm_w <= 1'b0;
            mem_req <= 1'b0; state <= S_RESP;
          end else if (issue) begin
            mem_req <= 1'b1; mem_addr <= nx_addr; lvl_q <= nx_lvl;
            state <= S_READ;
          end
        end
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  p_entry_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000);
  p_prot_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && fault_code == 8'h04 |-> fault_addr[2] && fault_addr[1:0] != 2'b00);
  p_sec_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && sec_fetch_q |-> !perm_r && !perm_w && perm_x);
endmodule

// File: tb/xlate_walker_test.sv
`timescale 1ns/1ps
module xlate_walker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, xlate_en = 1'b1, wide_addr = 1'b1;
  logic [63:0] req_va = 64'h0, root_pri = 64'h0, root_sec = 64'h0, root_home = 64'h0;
  logic [1:0]  req_kind = 2'd0, req_mode = 2'd1;
  logic        busy, mem_req, mem_ack = 1'b0, done, fault, perm_r, perm_w, perm_x;
  logic [63:0] mem_addr, mem_data = 64'h0, fault_addr, real_addr;
  logic [7:0]  fault_code;

  xlate_walker uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_kind(req_kind), .req_mode(req_mode), .xlate_en(xlate_en), .wide_addr(wide_addr),
    .root_pri(root_pri), .root_sec(root_sec), .root_home(root_home), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .done(done), .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr),
    .real_addr(real_addr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x));

  typedef struct {
    logic        f;
    logic [7:0]  code;
    logic [63:0] faddr, raddr;
    logic        r, w, x;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] mem [logic [63:0]];
  logic [63:0] path_addr [0:4];
  logic [63:0] next_tab = 64'h0010_0000;
  int nchk = 0, nbad = 0, rd_cnt = 0;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h20;
  endfunction

  function automatic logic [63:0] offs(input int l, input logic [63:0] v);
    case (l)
      4: return (v >> 50) & 64'h3ff8;
      3: return (v >> 39) & 64'h3ff8;
      2: return (v >> 28) & 64'h3ff8;
      1: return (v >> 17) & 64'h3ff8;
      default: return (v >> 9) & 64'h07f8;
    endcase
  endfunction

  // expected result straight from R1..R11
  function automatic exp_t model(input logic [63:0] va_in, input logic [1:0] kind, mode,
                                 input logic en, a64);
    exp_t e;
    logic [63:0] va, root, lim, org, d;
    logic [1:0] asc;
    int t;
    e.f = 0; e.code = 0; e.faddr = 0; e.reads = 0; e.r = 1; e.w = 1; e.x = 1;
    va = (a64 ? va_in : (va_in & 64'h7fff_ffff)) & ~64'hfff;
    e.raddr = va;
    if (!en) return e;
    asc = (mode == 2 && kind == 2) ? 2'd1 : mode;
    root = (asc == 1) ? root_pri : (asc == 2) ? root_sec : root_home;
    if (mode == 2) begin
      if (kind == 2) begin e.r = 0; e.w = 0; end else e.x = 0;
    end
    t = int'(root[3:2]);
    lim = (t == 2) ? 64'hffe0_0000_0000_0000 : (t == 1) ? 64'hffff_fc00_0000_0000 :
          (t == 0) ? 64'hffff_ffff_8000_0000 : 64'h0;
    e.faddr = va | {62'h0, asc};
    if ((va & lim) != 0) begin e.f = 1; e.code = 8'h12; return e; end
    if (root[5]) begin e.f = 1; e.code = 8'h10; return e; end
    if (root[4]) return e;
    org = root & ~64'hfff;
    for (int l = t + 1; l >= 1; l--) begin
      d = rd(org + offs(l, va)); e.reads++;
      if (d[5]) begin e.f = 1; e.code = 8'h10; return e; end
      if (int'(d[3:2]) != l - 1) begin e.f = 1; e.code = 8'h12; return e; end
      org = (l == 1) ? (d & ~64'h7ff) : (d & ~64'hfff);
    end
    d = rd(org + offs(0, va)); e.reads++;
    if (d[10]) begin e.f = 1; e.code = 8'h11; return e; end
    if (d[9]) e.w = 0;
    if (kind == 1 && !e.w) begin e.f = 1; e.code = 8'h04; e.faddr = e.faddr | 64'h4; return e; end
    e.raddr = d & ~64'hfff;
    return e;
  endfunction

  task automatic build(input logic [63:0] root_org, input int t, input logic [63:0] va,
                       input logic [63:0] pte);
    logic [63:0] org;
    org = root_org;
    for (int l = t + 1; l >= 1; l--) begin
      path_addr[l] = org + offs(l, va);
      mem[path_addr[l]] = next_tab | (64'(l - 1) << 2);
      org = next_tab;
      next_tab = next_tab + 64'h1_0000;
    end
    path_addr[0] = org + offs(0, va);
    mem[path_addr[0]] = pte;
  endtask

  task automatic xl(input logic [63:0] va, input logic [1:0] kind, mode, input logic en, a64,
                    input string tag, input bit stray = 1'b0);
    exp_t e;
    e = model(va, kind, mode, en, a64);
    e.tag = tag;
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_cnt = 0;
    sb.push_back(e);
    req_va = va; req_kind = kind; req_mode = mode; xlate_en = en; wide_addr = a64;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin
      req_va = ~va; req_kind = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // memory model: acknowledges every other cycle
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1; mem_data = rd(mem_addr); rd_cnt++;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      nchk++;
      if (sb.size() == 0) begin
        nbad++;
        $display("FAIL R12 extra done: got done=1 exp none");
      end else begin
        exp_t e;
        bit ok;
        e = sb.pop_front();
        ok = (fault == e.f) && (rd_cnt == e.reads) &&
             (e.f ? (fault_code == e.code && fault_addr == e.faddr)
                  : (real_addr == e.raddr && perm_r == e.r && perm_w == e.w && perm_x == e.x));
        if (!ok) begin
          nbad++;
          $display("FAIL %s got f=%0b code=%h fa=%h ra=%h rwx=%0b%0b%0b rd=%0d exp f=%0b code=%h fa=%h ra=%h rwx=%0b%0b%0b rd=%0d",
                   e.tag, fault, fault_code, fault_addr, real_addr, perm_r, perm_w, perm_x, rd_cnt,
                   e.f, e.code, e.faddr, e.raddr, e.r, e.w, e.x, e.reads);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (busy || done || mem_req) begin
      nbad++;
      $display("FAIL R12 reset: got busy=%0b done=%0b req=%0b exp 000", busy, done, mem_req);
    end

    // R1 / R2 bypass
    xl(64'h0123_4567_89ab_cdef, 2'd1, 2'd1, 1'b0, 1'b1, "R1 bypass 64-bit");
    xl(64'h0123_4567_89ab_cdef, 2'd0, 2'd2, 1'b0, 1'b0, "R2 bypass 31-bit");

    // R3/R4 region-first walk on primary
    root_pri = 64'h0001_0000 | (64'd3 << 2);
    build(64'h0001_0000, 3, 64'hA5C3_1234_5678_9000, 64'h0000_00AB_CDEF_0000);
    xl(64'hA5C3_1234_5678_9abc, 2'd0, 2'd1, 1'b1, 1'b1, "R4 region-first walk");
    xl(64'hA5C3_1234_5678_9abc, 2'd1, 2'd1, 1'b1, 1'b1, "R12 stray request ignored", 1'b1);
    // R11 secondary fetch uses primary root
    xl(64'hA5C3_1234_5678_9abc, 2'd2, 2'd2, 1'b1, 1'b1, "R11 secondary fetch");

    // R3 home root, region-second start
    root_home = 64'h0002_0000 | (64'd2 << 2);
    build(64'h0002_0000, 2, 64'h0012_3456_789A_B000, 64'h0000_0000_1234_5000);
    xl(64'h0012_3456_789A_B123, 2'd1, 2'd3, 1'b1, 1'b1, "R3 home root");
    xl(64'h0040_0000_0000_0000, 2'd0, 2'd3, 1'b1, 1'b1, "R5 region-second reach");

    // R11 secondary data, region-third start
    root_sec = 64'h0003_0000 | (64'd1 << 2);
    build(64'h0003_0000, 1, 64'h0000_0345_6789_A000, 64'h0000_0000_0777_7000);
    xl(64'h0000_0345_6789_A010, 2'd0, 2'd2, 1'b1, 1'b1, "R11 secondary data");
    xl(64'h0000_0400_0000_0000, 2'd0, 2'd2, 1'b1, 1'b1, "R5 region-third reach");

    // segment root on primary
    root_pri = 64'h0004_0000;
    build(64'h0004_0000, 0, 64'h0000_0000_0765_4000, 64'h0000_0000_0055_5000 | 64'h200);
    xl(64'h0000_0001_0000_0000, 2'd0, 2'd1, 1'b1, 1'b1, "R5 segment reach");
    xl(64'h0000_0001_0000_0000, 2'd2, 2'd2, 1'b1, 1'b1, "R10 secondary fetch fault tag");
    xl(64'hFFFF_FFFF_8765_4321, 2'd0, 2'd1, 1'b1, 1'b0, "R2 31-bit masked walk");
    xl(64'h0000_0000_0765_4000, 2'd0, 2'd1, 1'b1, 1'b1, "R9 read-only page read");
    xl(64'h0000_0000_0765_4000, 2'd1, 2'd1, 1'b1, 1'b1, "R9 R10 protection");

    mem[path_addr[0]] = 64'h0000_0000_0055_5000 | 64'h400;
    xl(64'h0000_0000_0765_4000, 2'd0, 2'd1, 1'b1, 1'b1, "R6 page invalid");
    mem[path_addr[1]] = mem[path_addr[1]] | 64'h20;
    xl(64'h0000_0000_0765_4000, 2'd0, 2'd1, 1'b1, 1'b1, "R6 segment invalid");

    // region-first chain corruptions
    root_pri = 64'h0001_0000 | (64'd3 << 2);
    build(64'h0001_0000, 3, 64'hA5C3_1234_5678_9000, 64'h0000_00AB_CDEF_0000);
    mem[path_addr[3]] = (mem[path_addr[3]] & ~64'hc) | (64'd0 << 2);
    xl(64'hA5C3_1234_5678_9000, 2'd0, 2'd1, 1'b1, 1'b1, "R7 type mismatch");
    mem[path_addr[4]] = mem[path_addr[4]] | 64'h20;
    xl(64'hA5C3_1234_5678_9000, 2'd0, 2'd1, 1'b1, 1'b1, "R6 region invalid");

    root_pri = 64'h0001_0000 | (64'd3 << 2) | 64'h20;
    xl(64'hA5C3_1234_5678_9000, 2'd0, 2'd1, 1'b1, 1'b1, "R6 root invalid");
    root_pri = 64'h0001_0000 | 64'h10;
    xl(64'h0000_0000_1111_2345, 2'd1, 2'd1, 1'b1, 1'b1, "R8 real-space root");

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule